// File: doc/BRIEF.md
# Double-Precision Base-2 Exponential Approximator

This block is a pipelined arithmetic unit. It takes one IEEE-754 binary64 operand x and, four clock cycles later, returns an approximation of 2^x in binary64. The relative error of every finite, in-range result against the true value stays below 2^-23. When x is an integer, the result is exactly 2^x. It accepts one operand per cycle, and a qualifying valid bit travels alongside each operand.

Internally, x is first converted to a signed fixed-point number with 40 fraction bits. That number is split into an integer part n and a fraction f in [0,1). The top six bits of f select one of 64 precomputed values of 2^(k/64). The remaining low-order part r < 1/64 is corrected by a degree-2 polynomial evaluated in fixed point. The product of the two becomes the significand, and n + 1023 becomes the biased exponent.

Special operands bypass this arithmetic. These are NaNs, infinities, zeros and subnormals, together with the out-of-range cases: results too large to represent and results that would be subnormal. Two flags report invalid and overflow conditions. Subnormal inputs and subnormal results are always flushed to zero, with no mode control.

Top module: `exp2_approx_f64`

## Requirements
- R1: Each operand accepted with valid_i high produces valid_o high exactly 4 clock cycles later. Back-to-back operands keep one result per cycle in order.
- R2: For finite non-integral x with -1022 <= x < 1024, the relative error of result_o against 2^x is below 2^-23. result_o is positive and finite, and both flags are low.
- R3: For integral x with -1022 <= x <= 1023, result_o is exactly 2^x: sign 0, biased exponent x+1023 in bits 62:52, and mantissa bits 51:0 equal to zero.
- R4: An operand whose exponent field (bits 62:52) is zero gives exactly 1.0 (0x3FF0000000000000) with no flag raised. This covers +0, -0 and subnormals.
- R5: A finite x below -1022 gives +0 (all 64 bits zero) with no flag raised. No subnormal result is ever produced.
- R6: A finite x of 1024 or more gives +infinity (0x7FF0000000000000) with overflow_o high.
- R7: +infinity gives +infinity, and -infinity gives +0. Neither raises a flag.
- R8: A NaN input returns the same 64 bits with the quiet bit (bit 51) set. invalid_o is high exactly when the input's bit 51 was 0, which marks a signalling NaN.
- R9: For non-integral x in [1023,1024) the result stays finite with biased exponent 2046, and overflow_o stays low.
- R10: While valid_o is low, invalid_o and overflow_o are low.
- R11: While rst_ni is low, valid_o, invalid_o and overflow_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | operand_i holds an operand this cycle |
| operand_i | input | 64 | binary64 exponent argument x |
| valid_o | output | 1 | result_o and flags hold a result this cycle |
| result_o | output | 64 | binary64 approximation of 2^x |
| invalid_o | output | 1 | Signalling NaN was consumed |
| overflow_o | output | 1 | Result exceeded the binary64 range |

## Verification
The bench aims at both edges of the range. At -1022 the result must be exact, while one unit in the last place below it must flush. A design that drops the shifted-out bits of x would return the smallest normal number there instead of zero. Just below 1024, a significand product reaching 2.0 would carry into an all-ones exponent and turn a finite result into infinity. Integral inputs expose any error in the table's first entry or in the polynomial's constant term. Signalling and quiet NaNs of both signs catch a flag tied to the wrong bit or a payload that is not preserved. Randomised operands also run back to back and with idle gaps, so a latency slip or a flag left high between results is reported cycle by cycle.

// File: rtl/exp2_pkg.sv
`timescale 1ns/1ps
package exp2_pkg;

  localparam logic [63:0] F64_ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] F64_PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] F64_QBIT = 64'h0008_0000_0000_0000;

  typedef struct packed {
    logic        spec;
    logic        inv;
    logic        ovf;
    logic [63:0] res;
  } bypass_t;

  // integer square root, bitwise
  function automatic logic [127:0] isqrt128(input logic [127:0] v);
    logic [127:0] acc;
    acc = '0;
    for (int b = 63; b >= 0; b--) begin
      logic [127:0] cand;
      cand = acc | (128'd1 << b);
      if (cand * cand <= v) acc = cand;
    end
    return acc;
  endfunction

  // 2^(k/2^idx_w) in Q1.52, via repeated square roots of 2 in Q.60
  function automatic logic [52:0] tbl_entry(input int k, input int idx_w);
    logic [127:0] root, acc;
    root = 128'd2 << 60;
    for (int i = 0; i < idx_w; i++) root = isqrt128(root << 60);
    acc = 128'd1 << 60;
    for (int j = 0; j < k; j++) acc = (acc * root) >> 60;
    return 53'((acc + 128'd128) >> 8);
  endfunction

endpackage

// File: rtl/exp2_classify.sv
`timescale 1ns/1ps
module exp2_classify
  import exp2_pkg::*;
#(
  parameter int FRAC_W = 40
) (
  input  logic [63:0]        x_i,
  output bypass_t            byp_o,
  output logic signed [11:0] n_o,
  output logic [FRAC_W-1:0]  f_o
);
  localparam int          FX_W  = FRAC_W + 12;
  localparam int          SH0   = 1075 - FRAC_W;
  localparam logic [10:0] E_BIG = 11'd1033;   // |x| >= 1024
  localparam logic [63:0] LIM   = 64'd1022 << FRAC_W;

  logic        sgn;
  logic [10:0] ex;
  logic [51:0] mt;
  logic [11:0] rs;
  logic [63:0] sig, mag;
  logic        sticky, flush;
  logic [FX_W-1:0] xfx;

  assign sgn = x_i[63];
  assign ex  = x_i[62:52];
  assign mt  = x_i[51:0];
  assign sig = {11'b0, 1'b1, mt};
  assign rs  = 12'(SH0) - {1'b0, ex};

  always_comb begin
    if (rs >= 12'd64) begin
      mag    = '0;
      sticky = 1'b1;
    end else begin
      mag    = sig >> rs;
      sticky = |(sig & ((64'd1 << rs) - 64'd1));
    end
  end

  assign xfx   = sgn ? -FX_W'(mag) : FX_W'(mag);
  assign n_o   = xfx[FX_W-1 -: 12];
  assign f_o   = xfx[FRAC_W-1:0];
  // bits lost by truncation still decide the -1022 boundary
  assign flush = sgn && ((ex >= E_BIG) || (mag > LIM) || (mag == LIM && sticky));

  always_comb begin
    byp_o = '{spec: 1'b1, inv: 1'b0, ovf: 1'b0, res: 64'd0};
    if (ex == 11'h7FF) begin
      if (mt != '0) begin
        byp_o.res = x_i | F64_QBIT;
        byp_o.inv = ~mt[51];
      end else begin
        byp_o.res = sgn ? 64'd0 : F64_PINF;
      end
    end else if (ex == 11'd0) begin
      byp_o.res = F64_ONE;
    end else if (!sgn && ex >= E_BIG) begin
      byp_o.res = F64_PINF;
      byp_o.ovf = 1'b1;
    end else if (!flush) begin
      byp_o.spec = 1'b0;
    end
  end

endmodule

// File: rtl/exp2_table.sv
`timescale 1ns/1ps
module exp2_table #(
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [52:0]      val_o
);
  localparam int DEPTH = 2 ** IDX_W;

  logic [52:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    localparam logic [52:0] ENT = exp2_pkg::tbl_entry(g, IDX_W);
    assign rom[g] = ENT;
  end

  assign val_o = rom[idx_i];

endmodule

// File: rtl/exp2_poly.sv
`timescale 1ns/1ps
module exp2_poly #(
  parameter int FRAC_W = 40,
  parameter int IDX_W  = 6,
  parameter int COEF_W = 36
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [FRAC_W-IDX_W-1:0]    r_i,
  output logic [FRAC_W:0]            p_o
);
  localparam int R_W  = FRAC_W - IDX_W;
  localparam int R2_W = 2 * R_W - FRAC_W;
  localparam int PA_W = COEF_W + R_W;
  localparam int PB_W = COEF_W + R2_W;
  localparam int RR_W = 2 * R_W;
  localparam int P_W  = FRAC_W + 1;

  localparam real LN2 = 0.6931471805599453;
  localparam real C2  = LN2 * LN2 / 2.0;
  localparam real C3  = LN2 * LN2 * LN2 / 6.0;
  // quadratic term widened to balance the dropped cubic over [0, 2^-IDX_W)
  localparam real CB  = C2 + C3 * 0.89 * (2.0 ** (-IDX_W));
  localparam logic [COEF_W-1:0] A_C = COEF_W'(longint'(LN2 * (2.0 ** COEF_W)));
  localparam logic [COEF_W-1:0] B_C = COEF_W'(longint'(CB * (2.0 ** COEF_W)));

  logic [R_W-1:0]  ar_q;
  logic [R2_W-1:0] r2_q;
  logic [P_W-1:0]  p_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ar_q <= '0;
      r2_q <= '0;
      p_q  <= '0;
    end else begin
      ar_q <= R_W'((PA_W'(A_C) * PA_W'(r_i)) >> COEF_W);
      r2_q <= R2_W'((RR_W'(r_i) * RR_W'(r_i)) >> FRAC_W);
      p_q  <= (P_W'(1) << FRAC_W) + P_W'(ar_q)
            + P_W'((PB_W'(B_C) * PB_W'(r2_q)) >> COEF_W);
    end
  end

  assign p_o = p_q;

endmodule

// File: rtl/exp2_pack.sv
`timescale 1ns/1ps
module exp2_pack #(
  parameter int FRAC_W = 40
) (
  input  logic [52:0]        t_i,
  input  logic [FRAC_W:0]    p_i,
  input  logic signed [11:0] n_i,
  output logic [63:0]        res_o
);
  localparam int PW = 53 + FRAC_W + 1;

  logic [PW-1:0] prod;
  logic          sat;
  logic [51:0]   mant;
  logic [10:0]   bexp;

  assign prod = PW'(t_i) * PW'(p_i);
  // significand reaching 2.0 must not carry into the exponent
  assign sat  = (prod >> (FRAC_W + 53)) != '0;
  assign mant = sat ? '1 : 52'(prod >> FRAC_W);
  assign bexp = 11'(n_i + 12'sd1023);
  assign res_o = {1'b0, bexp, mant};

endmodule

// File: rtl/exp2_approx_f64.sv
`timescale 1ns/1ps
module exp2_approx_f64
  import exp2_pkg::*;
#(
  parameter int FRAC_W = 40,
  parameter int IDX_W  = 6,
  parameter int COEF_W = 36
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [63:0] operand_i,
  output logic        valid_o,
  output logic [63:0] result_o,
  output logic        invalid_o,
  output logic        overflow_o
);
  localparam int R_W = FRAC_W - IDX_W;

  bypass_t            byp0, sp1, sp2, sp3;
  logic signed [11:0] n0, n1, n2, n3;
  logic [FRAC_W-1:0]  f0;
  logic [IDX_W-1:0]   idx1, idx2;
  logic [R_W-1:0]     r1;
  logic               v1, v2, v3;
  logic [52:0]        t2, t3;
  logic [FRAC_W:0]    p3;
  logic [63:0]        pack_res;
  logic               v_q, inv_q, ovf_q;
  logic [63:0]        res_q;

  exp2_classify #(.FRAC_W(FRAC_W)) u_cls (
    .x_i(operand_i), .byp_o(byp0), .n_o(n0), .f_o(f0)
  );

  // stage 1: classified operand
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1 <= 1'b0; sp1 <= '0; n1 <= '0; idx1 <= '0; r1 <= '0;
    end else begin
      v1   <= valid_i;
      sp1  <= byp0;
      n1   <= n0;
      idx1 <= f0[FRAC_W-1 -: IDX_W];
      r1   <= f0[R_W-1:0];
    end
  end

  exp2_poly #(.FRAC_W(FRAC_W), .IDX_W(IDX_W), .COEF_W(COEF_W)) u_poly (
    .clk_i(clk_i), .rst_ni(rst_ni), .r_i(r1), .p_o(p3)
  );

  exp2_table #(.IDX_W(IDX_W)) u_tbl (.idx_i(idx2), .val_o(t2));

  // stages 2 and 3: side channel follows the polynomial
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v2 <= 1'b0; sp2 <= '0; n2 <= '0; idx2 <= '0;
      v3 <= 1'b0; sp3 <= '0; n3 <= '0; t3 <= '0;
    end else begin
      v2 <= v1;  sp2 <= sp1; n2 <= n1; idx2 <= idx1;
      v3 <= v2;  sp3 <= sp2; n3 <= n2; t3 <= t2;
    end
  end

  exp2_pack #(.FRAC_W(FRAC_W)) u_pack (
    .t_i(t3), .p_i(p3), .n_i(n3), .res_o(pack_res)
  );

  // stage 4: output register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= 1'b0; inv_q <= 1'b0; ovf_q <= 1'b0; res_q <= '0;
    end else begin
      v_q   <= v3;
      inv_q <= v3 & sp3.inv;
      ovf_q <= v3 & sp3.ovf;
      res_q <= sp3.spec ? sp3.res : pack_res;
    end
  end

  assign valid_o    = v_q;
  assign result_o   = res_q;
  assign invalid_o  = inv_q;
  assign overflow_o = ovf_q;

  assert_daz_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && operand_i[62:52] == 11'd0) |=>
      (sp1.spec && sp1.res == F64_ONE && !sp1.inv && !sp1.ovf));

  assert_ovf_inf_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> (result_o == F64_PINF && !invalid_o));

  assert_no_subnormal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && result_o[62:52] == 11'd0) |-> (result_o[51:0] == '0));

  assert_quiet_nan_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (result_o[62:51] == 12'hFFF && !overflow_o));

  assert_positive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && result_o[62:52] != 11'h7FF) |-> !result_o[63]);

  assert_flag_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!invalid_o && !overflow_o));

endmodule

// File: tb/sim_exp2_approx_f64.sv
`timescale 1ns/1ps
module sim_exp2_approx_f64;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        valid_i;
  logic [63:0] operand_i;
  logic        valid_o, invalid_o, overflow_o;
  logic [63:0] result_o;

  always #2 clk = ~clk;

  exp2_approx_f64 u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .operand_i(operand_i),
    .valid_o(valid_o), .result_o(result_o), .invalid_o(invalid_o),
    .overflow_o(overflow_o)
  );

  localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit mon_en = 0, done = 0;
  int unsigned st = 32'h1234_5678;
  logic [63:0] q_op[$];
  int          q_cyc[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int unsigned nxt();
    st ^= st << 13; st ^= st >> 17; st ^= st << 5;
    return st;
  endfunction

  task automatic judge(input logic [63:0] op, input logic [63:0] res, input logic inv, input logic ovf);
    logic [10:0] e;
    logic [51:0] m;
    logic [63:0] eb;
    real xr, rv, got, rel;
    e  = op[62:52];
    m  = op[51:0];
    xr = $bitstoreal(op);
    if (e == 11'h7FF && m != '0) begin
      eb = op | (64'd1 << 51);
      chk(res == eb, "R8 nan payload", res, eb);
      chk(inv == !m[51] && !ovf, "R8 invalid flag", {62'b0, inv, ovf}, {62'b0, !m[51], 1'b0});
    end else if (e == 11'h7FF) begin
      eb = op[63] ? 64'd0 : PINF;
      chk(res == eb && !inv && !ovf, "R7 infinity", res, eb);
    end else if (e == 11'd0) begin
      chk(res == ONE && !inv && !ovf, "R4 zero/subnormal in", res, ONE);
    end else if (xr >= 1024.0) begin
      chk(res == PINF && ovf && !inv, "R6 overflow", res, PINF);
    end else if (xr < -1022.0) begin
      chk(res == 64'd0 && !inv && !ovf, "R5 flush", res, 64'd0);
    end else if ($floor(xr) == xr) begin
      eb = {1'b0, 11'($rtoi(xr) + 1023), 52'b0};
      chk(res == eb && !inv && !ovf, "R3 integral exact", res, eb);
    end else begin
      rv  = $pow(2.0, xr);
      got = $bitstoreal(res);
      rel = (got - rv) / rv;
      if (rel < 0.0) rel = -rel;
      chk(rel < 2.0 ** (-23) && !inv && !ovf && res[62:52] != 11'h7FF && !res[63],
          "R2 relative error", res, $realtobits(rv));
      if (xr >= 1023.0)
        chk(res[62:52] == 11'h7FE && !ovf, "R9 top octave finite", res, 64'h7FEF_FFFF_FFFF_FFFF);
    end
  endtask

  always @(negedge clk) begin
    logic [63:0] op;
    int c;
    if (mon_en) begin
      if (valid_o) begin
        if (q_op.size() == 0) chk(1'b0, "R1 unexpected valid", result_o, 64'd0);
        else begin
          op = q_op.pop_front();
          c  = q_cyc.pop_front();
          chk(cyc == c + 4, "R1 latency", 64'(cyc), 64'(c + 4));
          judge(op, result_o, invalid_o, overflow_o);
        end
      end else begin
        chk(!invalid_o && !overflow_o, "R10 flags idle", {62'b0, invalid_o, overflow_o}, 64'd0);
        if (q_cyc.size() != 0 && q_cyc[0] + 4 <= cyc) begin
          chk(1'b0, "R1 missing result", 64'(cyc), 64'(q_cyc[0] + 4));
          void'(q_op.pop_front());
          void'(q_cyc.pop_front());
        end
      end
    end
  end

  task automatic send(input logic [63:0] x);
    @(negedge clk);
    valid_i   = 1'b1;
    operand_i = x;
    q_op.push_back(x);
    q_cyc.push_back(cyc);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      valid_i = 1'b0;
    end
  endtask

  task automatic gen(output logic [63:0] x);
    int unsigned k;
    k = nxt() % 4;
    case (k)
      0: x = $realtobits(real'(int'(nxt() % 2100000) - 1050000) / 1000.0);
      1: x = $realtobits(real'(int'(nxt() % 2000001) - 1000000) / 1.0e6);
      2: x = $realtobits(real'(int'(nxt() % 2100) - 1050));
      default: x = {nxt(), nxt()};
    endcase
  endtask

  localparam int ND = 25;
  logic [63:0] dir [ND] = '{
    64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h000F_FFFF_FFFF_FFFF,
    64'h8000_0000_0000_0001, 64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000,
    64'h7FF8_0000_0000_0123, 64'h7FF0_0000_0000_0001, 64'hFFF4_0000_0000_0000,
    64'h3FF0_0000_0000_0000, 64'h4024_0000_0000_0000, 64'hBFF0_0000_0000_0000,
    64'hC08F_F000_0000_0000, 64'hC08F_F000_0000_0001, 64'hC08F_F800_0000_0000,
    64'h408F_F800_0000_0000, 64'h408F_FFFF_FFFF_FFFF, 64'h4090_0000_0000_0000,
    64'h7FEF_FFFF_FFFF_FFFF, 64'hFFEF_FFFF_FFFF_FFFF, 64'h3FE0_0000_0000_0000,
    64'hBFE0_0000_0000_0000, 64'h3F8F_FFFF_FFFF_FFFF, 64'h3C00_0000_0000_0000,
    64'hC08F_EFFF_FFFF_FFFF
  };

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  always @(posedge clk) begin
    if (cyc > 50000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog actual=%0d expected=below 50000 cycles", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] x;
    rst_ni    = 1'b0;
    valid_i   = 1'b0;
    operand_i = '0;
    repeat (3) @(negedge clk);
    chk(!valid_o && !invalid_o && !overflow_o, "R11 reset outputs",
        {61'b0, valid_o, invalid_o, overflow_o}, 64'd0);
    rst_ni = 1'b1;
    mon_en = 1'b1;
    idle(2);
    for (int i = 0; i < ND; i++) send(dir[i]);
    idle(6);
    for (int i = 0; i < ND; i++) begin
      send(dir[i]);
      idle(1 + i % 3);
    end
    for (int i = 0; i < 800; i++) begin
      gen(x);
      send(x);
      if (nxt() % 5 == 0) idle(int'(nxt() % 4));
    end
    idle(10);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule